// File: doc/BRIEF.md
# Branch Coverage Counter Unit

This block gathers per-branch execution statistics from a stream of control-flow events. An upstream reconstruction stage produces one event for each executed branch instruction. Each event gives a table index for the branch location in the object code, a flag that says whether the branch is conditional, and a flag that says whether it redirected control flow. For every table entry the block keeps two saturating counters: one for sequential continuations and one for redirections. For conditional branches it also keeps two sticky coverage bits: the branch has been seen taken, and the branch has been seen falling through.

Host software follows coverage progress during a running test. It pulses a snapshot request, which copies the whole live table into a shadow table in a single cycle. Software then reads the shadow table one entry at a time through a combinational read port, while new events continue to update the live table. A synchronous clear input empties both tables before a new run.

Incoming events use a valid/ready handshake. The block accepts one event on every cycle, including long bursts that hit the same index. It does this with a two-stage read-modify-write pipeline that forwards the in-flight result.

Top module: `branch_cov_counter`

## Requirements
- R1: A conditional event with the taken flag low increments that entry's fall-through counter by one and sets its seen-fall-through bit.
- R2: A conditional event with the taken flag high increments that entry's taken counter by one and sets its seen-taken bit.
- R3: An unconditional event increments the entry's taken counter whatever the value of its taken flag. It leaves the fall-through counter and both coverage bits unchanged, so an entry used only by unconditional events reads fall-through 0 and both bits 0.
- R4: A coverage bit, once set, stays set until clear or reset.
- R5: Both counters saturate at 2^CNT_W-1 and never wrap. With the default CNT_W of 8 the limit is 255.
- R6: A one-cycle pulse on snap_i copies every entry into the shadow table. The copy includes every event accepted in an earlier cycle and leaves out an event accepted in the same cycle as the pulse.
- R7: The read port shows the shadow entry selected by rd_idx_i combinationally. Shadow contents change only on a snapshot, a clear or a reset, so events accepted after a snapshot do not show until the next snapshot.
- R8: Events are accepted one per cycle. Back-to-back events to the same index are all counted.
- R9: While clear_i is high, ev_ready_o is low and no event is accepted. After a clear cycle, all live and shadow counters and bits read 0, and any event still in flight is dropped.
- R10: After reset, every shadow entry reads 0 and ev_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of both tables |
| ev_valid_i | input | 1 | Branch event present |
| ev_ready_o | output | 1 | Block can accept an event |
| ev_idx_i | input | IDX_W | Branch table index |
| ev_cond_i | input | 1 | 1 = conditional branch |
| ev_taken_i | input | 1 | 1 = control flow redirected |
| snap_i | input | 1 | Copy live table to shadow table |
| rd_idx_i | input | IDX_W | Shadow entry to read |
| rd_fall_o | output | CNT_W | Fall-through count of the selected entry |
| rd_taken_o | output | CNT_W | Taken count of the selected entry |
| rd_seen_taken_o | output | 1 | Conditional branch has been seen taken |
| rd_seen_fall_o | output | 1 | Conditional branch has been seen falling through |

## Verification
The bench aims at the read-modify-write hazard. It sends bursts of back-to-back and alternating events to the same indices. A design without forwarding would lose every other increment. It checks the snapshot boundary by accepting an event in the same cycle as the request and then firing events during readout. A leaky shadow would show those counts early, and a late copy would miss the last event before the request. It pushes both counters past their limit, where a wrapping counter would read a small value, and it sends unconditional events with the taken flag low, which a careless decoder would count as fall-throughs or coverage. Finally it drives events during a clear, and a design that accepted them would show non-zero counts after the clear.

// File: rtl/bcc_pkg.sv
// Package: shared event classification for the branch coverage counter.
// Assumes an event is only meaningful when it is accepted by the handshake.
package bcc_pkg;

    typedef enum logic [1:0] {
        BR_NONE  = 2'd0,  // no update
        BR_FALL  = 2'd1,  // conditional, fell through
        BR_TAKEN = 2'd2,  // conditional, redirected
        BR_JUMP  = 2'd3   // unconditional branch or call
    } br_kind_e;

    // Map the event flags to the kind of counter update.
    function automatic br_kind_e classify(input logic acc, input logic cond, input logic taken);
        if (!acc)
            return BR_NONE;
        else if (!cond)
            return BR_JUMP;
        else if (taken)
            return BR_TAKEN;
        else
            return BR_FALL;
    endfunction

endpackage

// File: rtl/bcc_entry_update.sv
// Module: bcc_entry_update
// Computes the new value of one statistics entry from its old value and the
// update kind. Entry layout: {seen_fall, seen_taken, taken_cnt, fall_cnt}.
// Assumes the caller writes the result back only for a real event.
module bcc_entry_update
    import bcc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  br_kind_e                 kind,
    input  logic [2*CNT_W+1:0]       old_ent,
    output logic [2*CNT_W+1:0]       new_ent
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] fall_old, taken_old, fall_new, taken_new;
    logic             seen_t_old, seen_f_old, seen_t_new, seen_f_new;

    assign fall_old   = old_ent[CNT_W-1:0];
    assign taken_old  = old_ent[2*CNT_W-1:CNT_W];
    assign seen_t_old = old_ent[2*CNT_W];
    assign seen_f_old = old_ent[2*CNT_W+1];

    // Apply a saturating increment and the sticky flag for the selected kind.
    always_comb begin
        fall_new   = fall_old;
        taken_new  = taken_old;
        seen_t_new = seen_t_old;
        seen_f_new = seen_f_old;
        unique case (kind)
            BR_FALL: begin
                fall_new   = (fall_old == CNT_MAX) ? fall_old : fall_old + CNT_ONE;
                seen_f_new = 1'b1;
            end
            BR_TAKEN: begin
                taken_new  = (taken_old == CNT_MAX) ? taken_old : taken_old + CNT_ONE;
                seen_t_new = 1'b1;
            end
            BR_JUMP: begin
                taken_new  = (taken_old == CNT_MAX) ? taken_old : taken_old + CNT_ONE;
            end
            default: ;
        endcase
    end

    assign new_ent = {seen_f_new, seen_t_new, taken_new, fall_new};

endmodule

// File: rtl/bcc_fwd_stage.sv
// Module: bcc_fwd_stage
// First pipeline stage of the read-modify-write path. It registers an accepted
// event together with the entry value it will modify. If the write stage is
// updating the same index in this cycle, that pending value is forwarded in
// place of the stale table contents.
// Assumes the table write lands on the same edge that this stage samples.
module bcc_fwd_stage
    import bcc_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int ENT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  br_kind_e         in_kind,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [ENT_W-1:0] live_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    output logic             p_vld,
    output br_kind_e         p_kind,
    output logic [IDX_W-1:0] p_idx,
    output logic [ENT_W-1:0] p_old
);
    logic             hit;
    logic [ENT_W-1:0] src_data;

    assign hit      = wr_en && (wr_idx == in_idx);
    assign src_data = hit ? wr_data : live_data;

    // Capture the accepted event and its forwarded operand; drop it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            p_vld  <= 1'b0;
            p_kind <= BR_NONE;
            p_idx  <= '0;
            p_old  <= '0;
        end else begin
            p_vld <= (in_kind != BR_NONE);
            if (in_kind != BR_NONE) begin
                p_kind <= in_kind;
                p_idx  <= in_idx;
                p_old  <= src_data;
            end
        end
    end

endmodule

// File: rtl/bcc_table.sv
// Module: bcc_table
// Holds the live statistics table and its shadow copy in flops, so that a
// snapshot copies every entry in one cycle. The snapshot includes a write
// that is landing on the same edge. Clear has priority over write and snapshot.
// Assumes indices at or above N_ENTRIES are never written; reading them returns 0.
module bcc_table #(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = 4,
    parameter int ENT_W     = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             snap,
    input  logic [IDX_W-1:0] lrd_idx,
    output logic [ENT_W-1:0] lrd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] srd_idx,
    output logic [ENT_W-1:0] srd_data
);
    logic [ENT_W-1:0] live_arr   [N_ENTRIES];
    logic [ENT_W-1:0] shadow_arr [N_ENTRIES];

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_ent
        logic [ENT_W-1:0] live_q, shadow_q;
        logic             wr_hit;

        assign wr_hit = wr_en && (wr_idx == IDX_W'(k));

        // Live entry: take the pipelined update for this index.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                live_q <= '0;
            else if (wr_hit)
                live_q <= wr_data;
        end

        // Shadow entry: copy live contents, including a write landing now.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                shadow_q <= '0;
            else if (snap)
                shadow_q <= wr_hit ? wr_data : live_q;
        end

        assign live_arr[k]   = live_q;
        assign shadow_arr[k] = shadow_q;
    end

    assign lrd_data = (int'(lrd_idx) < N_ENTRIES) ? live_arr[lrd_idx]   : '0;
    assign srd_data = (int'(srd_idx) < N_ENTRIES) ? shadow_arr[srd_idx] : '0;

endmodule

// File: rtl/branch_cov_counter.sv
// Module: branch_cov_counter (top)
// Per-branch coverage statistics with a live table updated by a two-stage
// read-modify-write pipeline and a shadow table for host readout.
// Assumes one event per cycle at most; ready drops only while clear is high.
module branch_cov_counter
    import bcc_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int ENT_W    = 2*CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             ev_valid_i,
    output logic             ev_ready_o,
    input  logic [IDX_W-1:0] ev_idx_i,
    input  logic             ev_cond_i,
    input  logic             ev_taken_i,
    input  logic             snap_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [CNT_W-1:0] rd_fall_o,
    output logic [CNT_W-1:0] rd_taken_o,
    output logic             rd_seen_taken_o,
    output logic             rd_seen_fall_o
);
    br_kind_e         in_kind, p_kind;
    logic             p_vld;
    logic [IDX_W-1:0] p_idx;
    logic [ENT_W-1:0] p_old, wr_data, live_data, shadow_data;

    assign ev_ready_o = !clear_i;
    assign in_kind    = classify(ev_valid_i && ev_ready_o, ev_cond_i, ev_taken_i);

    bcc_fwd_stage #(.IDX_W(IDX_W), .ENT_W(ENT_W)) i_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_i),
        .in_kind  (in_kind),
        .in_idx   (ev_idx_i),
        .live_data(live_data),
        .wr_en    (p_vld),
        .wr_idx   (p_idx),
        .wr_data  (wr_data),
        .p_vld    (p_vld),
        .p_kind   (p_kind),
        .p_idx    (p_idx),
        .p_old    (p_old)
    );

    bcc_entry_update #(.CNT_W(CNT_W)) i_upd (
        .kind   (p_kind),
        .old_ent(p_old),
        .new_ent(wr_data)
    );

    bcc_table #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .ENT_W(ENT_W)) i_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_i),
        .snap    (snap_i),
        .lrd_idx (ev_idx_i),
        .lrd_data(live_data),
        .wr_en   (p_vld),
        .wr_idx  (p_idx),
        .wr_data (wr_data),
        .srd_idx (rd_idx_i),
        .srd_data(shadow_data)
    );

    assign rd_fall_o       = shadow_data[CNT_W-1:0];
    assign rd_taken_o      = shadow_data[2*CNT_W-1:CNT_W];
    assign rd_seen_taken_o = shadow_data[2*CNT_W];
    assign rd_seen_fall_o  = shadow_data[2*CNT_W+1];

endmodule

// File: rtl/bcc_checker.sv
// Module: bcc_checker
// Port-level properties of the branch coverage counter, bound to the top.
// Assumes the checker sees the same clock and reset as the design.
module bcc_checker #(
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             snap_i,
    input logic             ev_ready_o,
    input logic [IDX_W-1:0] rd_idx_i,
    input logic [CNT_W-1:0] rd_fall_o,
    input logic [CNT_W-1:0] rd_taken_o,
    input logic             rd_seen_taken_o,
    input logic             rd_seen_fall_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> (rd_fall_o == '0 && rd_taken_o == '0 && !rd_seen_taken_o && !rd_seen_fall_o));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_i && !clear_i) ##1 $stable(rd_idx_i)
        |-> ($stable(rd_fall_o) && $stable(rd_taken_o) && $stable(rd_seen_taken_o) && $stable(rd_seen_fall_o)));

    // R4
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(rd_seen_taken_o) || $fell(rd_seen_fall_o)) && $stable(rd_idx_i)) |-> $past(clear_i));

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_idx_i) && !$past(clear_i) && $past(rd_taken_o) == CNT_MAX) |-> rd_taken_o == CNT_MAX);

    // R1
    fall_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_idx_i) && !$past(clear_i)) |-> rd_fall_o >= $past(rd_fall_o));

    // R10
    ready_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (ev_ready_o || clear_i));

endmodule

bind branch_cov_counter bcc_checker #(.N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W)) i_bcc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear_i        (clear_i),
    .snap_i         (snap_i),
    .ev_ready_o     (ev_ready_o),
    .rd_idx_i       (rd_idx_i),
    .rd_fall_o      (rd_fall_o),
    .rd_taken_o     (rd_taken_o),
    .rd_seen_taken_o(rd_seen_taken_o),
    .rd_seen_fall_o (rd_seen_fall_o)
);

// File: tb/test_branch_cov_counter.sv
// Scoreboard bench: driver tasks keep a reference model and push expected
// shadow entries into a queue; a monitor pops and compares them mid-cycle.
module test_branch_cov_counter;
    localparam int N     = 16;
    localparam int CNT_W = 8;
    localparam int MAXC  = 255;

    logic             clk = 1'b0;
    logic             rst_n, clear_i, ev_valid_i, ev_cond_i, ev_taken_i, snap_i;
    logic             ev_ready_o, rd_seen_taken_o, rd_seen_fall_o;
    logic [3:0]       ev_idx_i, rd_idx_i;
    logic [CNT_W-1:0] rd_fall_o, rd_taken_o;

    always #10 clk = ~clk;  // 50 MHz

    branch_cov_counter #(.N_ENTRIES(N), .CNT_W(CNT_W)) i_branch_cov_counter (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .ev_valid_i(ev_valid_i), .ev_ready_o(ev_ready_o), .ev_idx_i(ev_idx_i),
        .ev_cond_i(ev_cond_i), .ev_taken_i(ev_taken_i), .snap_i(snap_i),
        .rd_idx_i(rd_idx_i), .rd_fall_o(rd_fall_o), .rd_taken_o(rd_taken_o),
        .rd_seen_taken_o(rd_seen_taken_o), .rd_seen_fall_o(rd_seen_fall_o)
    );

    // Reference model: live and shadow.
    int m_fall [N]; int m_tk [N]; bit m_st [N]; bit m_sf [N];
    int s_fall [N]; int s_tk [N]; bit s_st [N]; bit s_sf [N];

    typedef struct { int idx; int fall; int tk; bit st; bit sf; string req; } exp_t;
    exp_t q[$];
    int n_vec = 0;
    int n_fail = 0;

    function automatic void model_event(int idx, bit c, bit t);
        if (!c) begin
            if (m_tk[idx] < MAXC) m_tk[idx]++;
        end else if (t) begin
            if (m_tk[idx] < MAXC) m_tk[idx]++;
            m_st[idx] = 1'b1;
        end else begin
            if (m_fall[idx] < MAXC) m_fall[idx]++;
            m_sf[idx] = 1'b1;
        end
    endfunction

    function automatic void model_snap();
        for (int i = 0; i < N; i++) begin
            s_fall[i] = m_fall[i]; s_tk[i] = m_tk[i]; s_st[i] = m_st[i]; s_sf[i] = m_sf[i];
        end
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < N; i++) begin
            m_fall[i] = 0; m_tk[i] = 0; m_st[i] = 0; m_sf[i] = 0;
        end
        model_snap();
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one event for one cycle (valid stays high for back-to-back calls).
    task automatic send(int idx, bit c, bit t);
        @(negedge clk);
        ev_valid_i = 1'b1; ev_idx_i = 4'(idx); ev_cond_i = c; ev_taken_i = t;
        model_event(idx, c, t);
    endtask

    task automatic idle();
        @(negedge clk);
        ev_valid_i = 1'b0;
    endtask

    // Snapshot pulse; optionally with an event accepted in the same cycle (R6).
    task automatic snapshot(bit with_ev, int idx);
        @(negedge clk);
        snap_i = 1'b1;
        model_snap();
        ev_valid_i = with_ev;
        if (with_ev) begin
            ev_idx_i = 4'(idx); ev_cond_i = 1'b1; ev_taken_i = 1'b1;
            model_event(idx, 1'b1, 1'b1);
        end
        @(negedge clk);
        snap_i = 1'b0;
        ev_valid_i = 1'b0;
    endtask

    // Read every shadow entry; with busy set, events keep arriving (R7).
    task automatic read_all(string req, bit busy);
        for (int i = 0; i < N; i++) begin
            exp_t e;
            @(negedge clk);
            rd_idx_i = 4'(i);
            ev_valid_i = busy;
            if (busy) begin
                ev_idx_i = 4'(i); ev_cond_i = 1'b1; ev_taken_i = 1'b0;
                model_event(i, 1'b1, 1'b0);
            end
            e.idx = i; e.fall = s_fall[i]; e.tk = s_tk[i]; e.st = s_st[i]; e.sf = s_sf[i]; e.req = req;
            q.push_back(e);
        end
        @(negedge clk);
        ev_valid_i = 1'b0;
    endtask

    // Monitor: compare read port against the queued expectation mid-cycle.
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(int'(rd_fall_o) == e.fall, {e.req, " fall"}, int'(rd_fall_o), e.fall);
            check(int'(rd_taken_o) == e.tk, {e.req, " taken"}, int'(rd_taken_o), e.tk);
            check(rd_seen_taken_o == e.st, {e.req, " seen_taken"}, int'(rd_seen_taken_o), int'(e.st));
            check(rd_seen_fall_o == e.sf, {e.req, " seen_fall"}, int'(rd_seen_fall_o), int'(e.sf));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clear_i = 1'b0; ev_valid_i = 1'b0; ev_cond_i = 1'b0;
        ev_taken_i = 1'b0; snap_i = 1'b0; ev_idx_i = '0; rd_idx_i = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        #1 check(ev_ready_o == 1'b1, "R10 ready", int'(ev_ready_o), 1);
        read_all("R10 reset", 1'b0);

        // R1, R2, R3: mixed patterns, unconditional with taken low included
        for (int k = 0; k < 3; k++) send(0, 1'b1, 1'b1);
        for (int k = 0; k < 2; k++) send(0, 1'b1, 1'b0);
        send(1, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) send(2, 1'b1, 1'b0);
        send(3, 1'b0, 1'b1); send(3, 1'b0, 1'b0); send(3, 1'b0, 1'b1);
        send(15, 1'b0, 1'b0);
        idle();
        snapshot(1'b0, 0);
        read_all("R1 R2 R3 patterns", 1'b0);

        // R8: back-to-back and alternating bursts to the same indices
        for (int k = 0; k < 10; k++) send(9, 1'b1, 1'b1);
        for (int k = 0; k < 12; k++) send(10 + (k % 2), 1'b1, k[1]);
        // R6: last event right before the request, plus one in the request cycle
        send(12, 1'b1, 1'b0);
        snapshot(1'b1, 12);
        // R7: events during readout must not appear in the shadow
        read_all("R6 R8 snapshot", 1'b1);
        read_all("R7 shadow hold", 1'b0);
        snapshot(1'b0, 0);
        read_all("R7 next snapshot", 1'b0);

        // R5: saturation of both counters; R4 flags stay set
        for (int k = 0; k < 300; k++) send(5, 1'b0, 1'b1);
        for (int k = 0; k < 260; k++) send(6, 1'b1, 1'b0);
        send(6, 1'b1, 1'b1);
        idle();
        snapshot(1'b0, 0);
        read_all("R5 R4 saturate", 1'b0);

        // R9: clear with an event offered, which must not be accepted
        @(negedge clk);
        clear_i = 1'b1; ev_valid_i = 1'b1; ev_idx_i = 4'(7); ev_cond_i = 1'b1; ev_taken_i = 1'b1;
        model_clear();
        #1 check(ev_ready_o == 1'b0, "R9 ready low", int'(ev_ready_o), 0);
        @(negedge clk);
        clear_i = 1'b0; ev_valid_i = 1'b0;
        read_all("R9 shadow cleared", 1'b0);
        snapshot(1'b0, 0);
        read_all("R9 live cleared", 1'b0);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule